// File: doc/BRIEF.md
# Set-Associative Replacement Victim Selector

This block chooses which way of a cache set gets evicted when a new line must be brought in. It sees every access the cache makes (a hit to a way, or a fill that places a new line in a way) and keeps a small amount of state per set. It does not store tags or data. When the cache asks for a victim in a given set, the block answers on the same cycle with a way number.

A set whose ways are not all occupied always gives up its lowest-numbered empty way first. Once a set is full, a build-time parameter picks how the victim is chosen. Pseudo-random mode draws from a free-running shift register. Least-recently-used mode evicts the way that has gone longest without a hit or a fill. First-in first-out mode evicts the way that was filled longest ago, and hits do not affect it. The default geometry is 4 sets of 2 ways. The set count and the way count are parameters. A one-way build acts as a direct-mapped cache.

Top module: `repl_victim_sel`

## Requirements
- R1: While reset is asserted every way of every set is empty, so the victim for any requested set is way 0; the random source loads the seed 16'hACE1.
- R2: When the requested set has at least one empty way, the victim is the lowest-numbered empty way, under every policy.
- R3: An access with `acc_fill`=1 marks way `acc_way` of set `acc_set` as occupied from the next cycle on. An access with `acc_fill`=0 is a hit and changes no occupancy.
- R4: With POLICY=VSEL_LRU and a full set, the victim is the way whose latest hit or fill is the oldest. Every access, hit or fill, makes its way the most recent.
- R5: With POLICY=VSEL_FIFO and a full set, the victim is the way whose latest fill is the oldest. Hits leave this order unchanged.
- R6: With POLICY=VSEL_RANDOM and a full set, the victim is the random state modulo NUM_WAYS. The state is 16 bits wide and shifts right on every clock after reset. When the bit shifted out is 1, the state is XORed with 16'hB400. The state is never zero.
- R7: With NUM_WAYS=1 (direct mapped) the victim is always way 0.
- R8: The victim reflects the state before any access presented in the same cycle, even when that access is a fill to the requested set.
- R9: An access changes only the state of the set that `acc_set` selects. Each set is numbered as block number mod NUM_SETS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access event is presented this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | WAY_W | Way that was hit or filled |
| acc_fill | input | 1 | 1: fill of a new line, 0: hit |
| req_set | input | SET_W | Set whose victim is requested |
| victim_way | output | WAY_W | Way to evict from `req_set` (combinational) |

## Verification
On every cycle the assertions check three things. The victim never skips a lower empty way. A filled way reads as occupied on the next cycle. In LRU mode the way just accessed becomes the most recent. They also check that FIFO state holds still across hits, that the random state never reaches zero, and that nothing is occupied during reset. Whether the chosen way is really the oldest by recency or by fill time, whether the random choices follow the stated sequence, and whether a same-cycle fill stays invisible to the requested set all depend on access history. Only the bench's timestamp models show these, running over long mixed sequences and the directed corner cases.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

  typedef enum logic [1:0] {
    VSEL_RANDOM = 2'd0,
    VSEL_LRU    = 2'd1,
    VSEL_FIFO   = 2'd2
  } vsel_policy_e;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hB400;

  // One right shift of the Galois register; the feedback mask is applied
  // whenever the bit leaving the low end is set.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] cur);
    logic [LFSR_W-1:0] shifted;
    shifted = {1'b0, cur[LFSR_W-1:1]};
    return cur[0] ? (shifted ^ LFSR_MASK) : shifted;
  endfunction

endpackage

// File: rtl/vsel_lfsr.sv
module vsel_lfsr
  import vsel_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] state_o
);

  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= lfsr_step(state_q);
  end

  assign state_o = state_q;

endmodule

// File: rtl/vsel_rank_set.sv
// Recency/age ranking for the ways of one set. Rank 0 is the newest way and
// rank NUM_WAYS-1 is the oldest. The ranks always form a permutation.
module vsel_rank_set #(
  parameter int unsigned NUM_WAYS = 2,
  localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_en,
  input  logic [WAY_W-1:0]          upd_way,
  output logic [NUM_WAYS*WAY_W-1:0] ranks_o,
  output logic [WAY_W-1:0]          oldest_o
);

  localparam logic [WAY_W-1:0] OLDEST_RANK = WAY_W'(NUM_WAYS - 1);

  logic [WAY_W-1:0] rank_q [NUM_WAYS];
  logic [WAY_W-1:0] touched_rank;

  // New rank of one way after another way (or itself) is touched.
  function automatic logic [WAY_W-1:0] rank_after(
    input logic [WAY_W-1:0] cur,
    input logic [WAY_W-1:0] pivot,
    input logic             is_target
  );
    if (is_target)    return '0;
    if (cur < pivot)  return cur + WAY_W'(1);
    return cur;
  endfunction

  assign touched_rank = rank_q[upd_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WAYS; i++) rank_q[i] <= WAY_W'(i);
    end else if (upd_en) begin
      for (int i = 0; i < NUM_WAYS; i++)
        rank_q[i] <= rank_after(rank_q[i], touched_rank, upd_way == WAY_W'(i));
    end
  end

  always_comb begin
    oldest_o = '0;
    for (int i = 0; i < NUM_WAYS; i++)
      if (rank_q[i] == OLDEST_RANK) oldest_o = WAY_W'(i);
  end

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_flat
    assign ranks_o[g*WAY_W +: WAY_W] = rank_q[g];
  end

endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel
  import vsel_pkg::*;
#(
  parameter int unsigned       NUM_SETS = 4,
  parameter int unsigned       NUM_WAYS = 2,
  parameter vsel_policy_e      POLICY   = VSEL_LRU,
  parameter logic [LFSR_W-1:0] SEED     = 16'hACE1,
  localparam int unsigned SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             acc_fill,
  input  logic [SET_W-1:0] req_set,
  output logic [WAY_W-1:0] victim_way
);

  localparam int unsigned LINES = NUM_SETS * NUM_WAYS;
  localparam bit USE_RANK = (POLICY != VSEL_RANDOM) && (NUM_WAYS > 1);

  // Named internal events and state, brought out for the checker.
  logic                      evt_fill;
  logic                      evt_hit;
  logic [NUM_WAYS-1:0]       req_valid_vec;
  logic                      req_has_invalid;
  logic [LINES-1:0]          valid_flat;
  logic [LINES*WAY_W-1:0]    age_flat;
  logic [LFSR_W-1:0]         lfsr_q;

  logic [NUM_WAYS-1:0]       valid_q [NUM_SETS];
  logic [WAY_W-1:0]          oldest_by_set [NUM_SETS];
  logic [WAY_W-1:0]          first_empty;
  logic [WAY_W-1:0]          policy_way;

  assign evt_fill = acc_valid &&  acc_fill;
  assign evt_hit  = acc_valid && !acc_fill;

  function automatic logic [WAY_W-1:0] lowest_empty(input logic [NUM_WAYS-1:0] occ);
    logic [WAY_W-1:0] idx;
    idx = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--)
      if (!occ[i]) idx = WAY_W'(i);
    return idx;
  endfunction

  function automatic logic [WAY_W-1:0] pick_random(input logic [LFSR_W-1:0] s);
    return WAY_W'(32'(s) % NUM_WAYS);
  endfunction

  // Per-set occupancy and ranking.
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic set_sel;
    assign set_sel = acc_valid && (acc_set == SET_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   valid_q[s] <= '0;
      else if (set_sel && acc_fill) valid_q[s][acc_way] <= 1'b1;
    end

    assign valid_flat[s*NUM_WAYS +: NUM_WAYS] = valid_q[s];

    if (USE_RANK) begin : g_rank
      logic rank_upd;
      assign rank_upd = set_sel && ((POLICY == VSEL_LRU) || acc_fill);

      vsel_rank_set #(.NUM_WAYS(NUM_WAYS)) u_rank (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (rank_upd),
        .upd_way  (acc_way),
        .ranks_o  (age_flat[s*NUM_WAYS*WAY_W +: NUM_WAYS*WAY_W]),
        .oldest_o (oldest_by_set[s])
      );
    end else begin : g_norank
      assign age_flat[s*NUM_WAYS*WAY_W +: NUM_WAYS*WAY_W] = '0;
      assign oldest_by_set[s] = '0;
    end
  end

  // Random source only exists in the random build.
  if (POLICY == VSEL_RANDOM) begin : g_rand
    vsel_lfsr #(.SEED(SEED)) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_o (lfsr_q)
    );
  end else begin : g_norand
    assign lfsr_q = SEED;
  end

  // Victim choice from registered state only (same-cycle accesses unseen).
  assign req_valid_vec   = valid_q[req_set];
  assign req_has_invalid = ~&req_valid_vec;
  assign first_empty     = lowest_empty(req_valid_vec);

  always_comb begin
    if (POLICY == VSEL_RANDOM) policy_way = pick_random(lfsr_q);
    else                       policy_way = oldest_by_set[req_set];
  end

  if (NUM_WAYS == 1) begin : g_direct
    assign victim_way = '0;
  end else begin : g_assoc
    assign victim_way = req_has_invalid ? first_empty : policy_way;
  end

endmodule

// File: rtl/repl_victim_sel_chk.sv
module repl_victim_sel_chk
  import vsel_pkg::*;
#(
  parameter int unsigned  NUM_SETS = 4,
  parameter int unsigned  NUM_WAYS = 2,
  parameter vsel_policy_e POLICY   = VSEL_LRU,
  localparam int unsigned SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int unsigned LINES = NUM_SETS * NUM_WAYS
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_valid,
  input logic [SET_W-1:0]       acc_set,
  input logic [WAY_W-1:0]       acc_way,
  input logic                   acc_fill,
  input logic                   evt_hit,
  input logic [WAY_W-1:0]       victim_way,
  input logic [NUM_WAYS-1:0]    req_valid_vec,
  input logic                   req_has_invalid,
  input logic [LINES-1:0]       valid_flat,
  input logic [LINES*WAY_W-1:0] age_flat,
  input logic [LFSR_W-1:0]      lfsr_q
);

  logic [31:0]         acc_idx;
  logic [NUM_WAYS-1:0] below_mask;

  assign acc_idx    = 32'(acc_set) * NUM_WAYS + 32'(acc_way);
  assign below_mask = (NUM_WAYS'(1) << victim_way) - NUM_WAYS'(1);

  // R1: nothing is occupied while reset holds
  always @(negedge clk) begin
    if (!rst_n) a_r1_empty_in_reset: assert (valid_flat == '0);
  end

  // R2: an empty way is preferred, and no lower way is empty
  a_r2_lowest_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (req_has_invalid && NUM_WAYS > 1) |->
      (!req_valid_vec[victim_way] && ((~req_valid_vec & below_mask) == '0)));

  // R3: a fill leaves its way occupied on the next cycle
  a_r3_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_fill) |=> valid_flat[$past(acc_idx)]);

  // R4: in LRU mode the accessed way becomes the newest
  a_r4_lru_newest: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == VSEL_LRU && NUM_WAYS > 1 && acc_valid) |=>
      (age_flat[$past(acc_idx)*WAY_W +: WAY_W] == '0));

  // R5: in FIFO mode a hit leaves the fill order alone
  a_r5_fifo_hit_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == VSEL_FIFO && evt_hit) |=> $stable(age_flat));

  // R6: the random state never collapses to zero
  a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == VSEL_RANDOM) |-> (lfsr_q != '0));

endmodule

bind repl_victim_sel repl_victim_sel_chk #(
  .NUM_SETS (NUM_SETS),
  .NUM_WAYS (NUM_WAYS),
  .POLICY   (POLICY)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .acc_valid       (acc_valid),
  .acc_set         (acc_set),
  .acc_way         (acc_way),
  .acc_fill        (acc_fill),
  .evt_hit         (evt_hit),
  .victim_way      (victim_way),
  .req_valid_vec   (req_valid_vec),
  .req_has_invalid (req_has_invalid),
  .valid_flat      (valid_flat),
  .age_flat        (age_flat),
  .lfsr_q          (lfsr_q)
);

// File: tb/tb_repl_victim_sel.sv
module tb_repl_victim_sel;
  import vsel_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SETS = 4;
  localparam int WAYS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [1:0] acc_set = '0;
  logic       acc_way = 1'b0;
  logic       acc_fill = 1'b0;
  logic [1:0] req_set = '0;
  logic       v_lru, v_fifo, v_rnd, v_dm;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  repl_victim_sel #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .POLICY(VSEL_LRU)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_way(acc_way), .acc_fill(acc_fill), .req_set(req_set), .victim_way(v_lru));

  repl_victim_sel #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .POLICY(VSEL_FIFO)) dut_fifo (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_way(acc_way), .acc_fill(acc_fill), .req_set(req_set), .victim_way(v_fifo));

  repl_victim_sel #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .POLICY(VSEL_RANDOM)) dut_rnd (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_way(acc_way), .acc_fill(acc_fill), .req_set(req_set), .victim_way(v_rnd));

  repl_victim_sel #(.NUM_SETS(SETS), .NUM_WAYS(1), .POLICY(VSEL_LRU)) dut_dm (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_way(1'b0), .acc_fill(acc_fill), .req_set(req_set), .victim_way(v_dm));

  // Timestamp models: occupancy, last touch, last fill, and the random state.
  bit          m_valid [SETS][WAYS];
  int          m_touch [SETS][WAYS];
  int          m_filled[SETS][WAYS];
  logic [15:0] m_rand;
  int          tick;

  function automatic logic [15:0] rand_next(input logic [15:0] s);
    return (s >> 1) ^ ({16{s[0]}} & 16'hB400);
  endfunction

  // kind: 0 LRU, 1 FIFO, 2 random
  function automatic int expect_way(int kind, int s);
    for (int w = 0; w < WAYS; w++)
      if (!m_valid[s][w]) return w;
    if (kind == 2) return int'(m_rand) % WAYS;
    if (kind == 0) return (m_touch[s][0] < m_touch[s][1]) ? 0 : 1;
    return (m_filled[s][0] < m_filled[s][1]) ? 0 : 1;
  endfunction

  function automatic bit set_full(int s);
    return m_valid[s][0] && m_valid[s][1];
  endfunction

  task automatic check(string tag, int got, int exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: victim got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(bit av, int s, int w, bit f, int rs, string note);
    string t_lru, t_fifo, t_rnd;
    @(negedge clk);
    acc_valid = av; acc_set = 2'(s); acc_way = 1'(w); acc_fill = f; req_set = 2'(rs);
    #1;
    t_lru  = (note != "") ? note : (set_full(rs) ? "R4 lru" : "R2 lru");
    t_fifo = (note != "") ? note : (set_full(rs) ? "R5 fifo" : "R2 fifo");
    t_rnd  = (note != "") ? note : (set_full(rs) ? "R6 random" : "R2 random");
    check(t_lru,  int'(v_lru),  expect_way(0, rs));
    check(t_fifo, int'(v_fifo), expect_way(1, rs));
    check(t_rnd,  int'(v_rnd),  expect_way(2, rs));
    check("R7 direct", int'(v_dm), 0);
    @(posedge clk);
    if (av) begin
      m_touch[s][w] = tick;
      if (f) begin
        m_valid[s][w]  = 1'b1;
        m_filled[s][w] = tick;
      end
    end
    tick++;
    m_rand = rand_next(m_rand);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_valid[s][w] = 1'b0; m_touch[s][w] = 0; m_filled[s][w] = 0;
      end
    tick = 1;
    m_rand = 16'hACE1;

    // R1: reset state, every set reports way 0
    repeat (2) @(posedge clk);
    for (int s = 0; s < SETS; s++) begin
      @(negedge clk);
      req_set = 2'(s);
      #1;
      check("R1 lru",    int'(v_lru),  0);
      check("R1 fifo",   int'(v_fifo), 0);
      check("R1 random", int'(v_rnd),  0);
      check("R1 direct", int'(v_dm),   0);
    end
    @(posedge clk);
    #1 rst_n = 1'b1;

    // Directed corner cases
    step(1, 0, 0, 1, 0, "R8 fill same cycle");   // pre-fill view: way 0
    step(0, 0, 0, 0, 0, "R3 fill marks way");    // way 0 occupied -> way 1
    step(1, 0, 1, 1, 0, "R8 fill same cycle");   // still way 1 this cycle
    step(0, 0, 0, 0, 0, "");                     // full: oldest is way 0
    step(1, 0, 0, 0, 0, "");                     // hit way 0
    step(0, 0, 0, 0, 0, "R5 hit keeps order");   // LRU -> 1, FIFO -> 0
    step(0, 0, 0, 0, 1, "R9 other set untouched");
    step(1, 2, 1, 1, 2, "R2 lowest empty");      // fill way 1 only
    step(0, 0, 0, 0, 2, "R2 lowest empty");      // way 0 still empty

    // Constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      bit av, f;
      int s, w, rs;
      av = ($urandom_range(0, 3) != 0);
      s  = $urandom_range(0, SETS - 1);
      w  = $urandom_range(0, WAYS - 1);
      f  = ($urandom_range(0, 2) == 0);
      if (!f && !m_valid[s][w]) f = 1'b1;
      rs = $urandom_range(0, SETS - 1);
      step(av, s, w, f, rs, "");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule